// File: doc/BRIEF.md
# Retire and Trap Controller

This block is the retire end of an out-of-order core for a single thread. The reorder buffer presents a window of its oldest entries, each with a set of status flags and a sequence number. On every cycle in which `tick_i` is high, the controller walks that window from the oldest slot. It removes squashed entries and commits ready ones, up to a configurable commit budget. It stops at the first entry it cannot retire.

Several head cases need special handling:

- An unexecuted instruction that must not run speculatively is released back to the execution side by sequence number.
- An unexecuted load is released with an uncached marker.
- A faulting instruction starts a trap countdown. When the countdown expires, the controller emits a one-cycle trap-squash pulse.

Two counters track activity. One counts committed work instructions. The other counts cycles that used the full commit budget. A drain handshake reports when the machine is quiescent.

All decisions are registered. Results of a tick sampled at a clock edge appear on the outputs right after that edge.

Top module: `retire_trap_ctrl`

## Requirements
- R1: On a tick, slots are visited oldest first (slot 0 first). The walk stops at the first slot that is invalid or not ready, or when COMMIT_WIDTH entries have already committed that tick. `pop_o` is therefore a contiguous run of ones from bit 0, and `commit_cnt_o` never exceeds COMMIT_WIDTH. Without a tick, `pop_o` is zero.
- R2: A squashed ready entry sets its `pop_o` bit but does not add to `commit_cnt_o` or use up commit budget.
- R3: An unexecuted head flagged non-speculative (this includes store-conditional and barrier operations) stops the walk without popping. It is released (`release_vld_o` high, `release_seq_o` equal to its sequence number, `release_uncached_o` low) only if nothing has committed earlier in the tick and `stores_pend_i` is low. Otherwise nothing is released.
- R4: An unexecuted load that is not flagged non-speculative stops the walk. It is released with `release_uncached_o` high and its sequence number, whatever the value of `stores_pend_i`.
- R5: An executed faulting entry stops the walk without popping. It arms the trap (`trap_pending_o` high) only if nothing has committed earlier in the tick and no stores are pending. Otherwise it waits.
- R6: Let E0 be the clock edge at which the trap is armed. At edge E0+TRAP_LATENCY, `trap_squash_o` goes high for exactly one cycle and `trap_pending_o` clears.
- R7: No entry is popped at any edge at which the trap was pending beforehand.
- R8: `fullbw_cnt_o` increments by one for each tick that commits exactly COMMIT_WIDTH entries. It does not change otherwise.
- R9: `inst_cnt_o` increases by the number of committed entries that are not flagged nop or instruction-prefetch (`head_nop_i`). Such flagged entries still pop and count toward `commit_cnt_o`.
- R10: `drained_o` is high in the cycle after an edge at which `drain_req_i` was high, `rob_empty_i` was high and `stores_pend_i` was low. It is low otherwise.
- R11: Reset clears pops, releases, the trap state, both counters and `drained_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Start a retire walk this cycle |
| head_vld_i | input | HEAD_DEPTH | Slot holds an entry |
| head_rdy_i | input | HEAD_DEPTH | Entry may be considered for retirement |
| head_sq_i | input | HEAD_DEPTH | Entry was squashed |
| head_exec_i | input | HEAD_DEPTH | Entry has executed |
| head_nonspec_i | input | HEAD_DEPTH | Entry must execute non-speculatively |
| head_load_i | input | HEAD_DEPTH | Entry is a load |
| head_fault_i | input | HEAD_DEPTH | Entry raised a fault |
| head_nop_i | input | HEAD_DEPTH | Entry is a nop or instruction prefetch |
| head_seq_i | input | HEAD_DEPTH*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W upward |
| stores_pend_i | input | 1 | Stores still awaiting writeback |
| drain_req_i | input | 1 | Drain requested |
| rob_empty_i | input | 1 | Reorder buffer empty |
| pop_o | output | HEAD_DEPTH | Slots removed on the last tick |
| commit_cnt_o | output | $clog2(COMMIT_WIDTH+1) | Entries committed on the last tick |
| release_vld_o | output | 1 | Release request valid |
| release_seq_o | output | SEQ_W | Sequence number being released |
| release_uncached_o | output | 1 | Release is for an uncached load |
| trap_pending_o | output | 1 | Trap countdown running |
| trap_squash_o | output | 1 | One-cycle trap-squash request |
| inst_cnt_o | output | CNT_W | Committed work instruction counter |
| fullbw_cnt_o | output | CNT_W | Full-budget tick counter |
| drained_o | output | 1 | Drain condition met |

## Verification
A wrong commit counter in the walk shows up on the first tick that follows. It appears as a `pop_o` run longer or shorter than the budget allows, or as missing full-budget increments on `fullbw_cnt_o`. A first-retire gate that is wrong shows within one tick, as a release or trap that should not have happened after a committed entry. A trap timer that is off by even one cycle moves `trap_squash_o` away from edge E0+TRAP_LATENCY. A timer that fails to block the walk shows as pops during the countdown, so the bench counts every edge of the trap window.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef struct packed {
    logic vld;
    logic rdy;
    logic sq;
    logic exec;
    logic nonspec;
    logic load;
    logic fault;
    logic nop;
  } head_flags_t;

  typedef enum logic {TRAP_IDLE, TRAP_WAIT} trap_state_e;
endpackage

// File: rtl/retire_scan.sv
module retire_scan
  import retire_pkg::*;
#(
  parameter int HEAD_DEPTH   = 6,
  parameter int COMMIT_WIDTH = 4,
  parameter int SEQ_W        = 16,
  localparam int CW_W        = $clog2(COMMIT_WIDTH + 1)
) (
  input  logic                        en_i,
  input  head_flags_t [HEAD_DEPTH-1:0] flags_i,
  input  logic [HEAD_DEPTH*SEQ_W-1:0] seq_i,
  input  logic                        stores_pend_i,
  output logic [HEAD_DEPTH-1:0]       pop_o,
  output logic [CW_W-1:0]             ncommit_o,
  output logic [CW_W-1:0]             nwork_o,
  output logic                        rel_vld_o,
  output logic                        rel_unc_o,
  output logic [SEQ_W-1:0]            rel_seq_o,
  output logic                        trap_fire_o
);
  logic stop;

  always_comb begin
    stop        = !en_i;
    pop_o       = '0;
    ncommit_o   = '0;
    nwork_o     = '0;
    rel_vld_o   = 1'b0;
    rel_unc_o   = 1'b0;
    rel_seq_o   = '0;
    trap_fire_o = 1'b0;
    for (int i = 0; i < HEAD_DEPTH; i++) begin
      if (!stop) begin
        if (!flags_i[i].vld || !flags_i[i].rdy || ncommit_o == CW_W'(COMMIT_WIDTH)) begin
          stop = 1'b1;
        end else if (flags_i[i].sq) begin
          pop_o[i] = 1'b1;  // squashed entries cost no budget
        end else if (!flags_i[i].exec) begin
          stop = 1'b1;
          if (flags_i[i].nonspec) begin
            if (ncommit_o == '0 && !stores_pend_i) begin
              rel_vld_o = 1'b1;
              rel_seq_o = seq_i[i*SEQ_W +: SEQ_W];
            end
          end else if (flags_i[i].load) begin
            rel_vld_o = 1'b1;
            rel_unc_o = 1'b1;
            rel_seq_o = seq_i[i*SEQ_W +: SEQ_W];
          end
        end else if (flags_i[i].fault) begin
          stop = 1'b1;
          if (ncommit_o == '0 && !stores_pend_i) trap_fire_o = 1'b1;
        end else begin
          pop_o[i]  = 1'b1;
          ncommit_o = ncommit_o + CW_W'(1);
          if (!flags_i[i].nop) nwork_o = nwork_o + CW_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trap_timer.sv
module trap_timer
  import retire_pkg::*;
#(
  parameter int TRAP_LATENCY = 5,
  localparam int LAT_W       = $clog2(TRAP_LATENCY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pending_o,
  output logic squash_o
);
  trap_state_e state_q;
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TRAP_IDLE;
      cnt_q    <= '0;
      squash_o <= 1'b0;
    end else begin
      squash_o <= 1'b0;
      case (state_q)
        TRAP_IDLE: if (fire_i) begin
          state_q <= TRAP_WAIT;
          cnt_q   <= LAT_W'(TRAP_LATENCY);
        end
        TRAP_WAIT: begin
          if (cnt_q == LAT_W'(1)) begin
            state_q  <= TRAP_IDLE;
            squash_o <= 1'b1;
          end
          cnt_q <= cnt_q - LAT_W'(1);
        end
        default: state_q <= TRAP_IDLE;
      endcase
    end
  end

  assign pending_o = (state_q == TRAP_WAIT);
endmodule

// File: rtl/retire_counters.sv
module retire_counters #(
  parameter int COMMIT_WIDTH = 4,
  parameter int CNT_W        = 16,
  localparam int CW_W        = $clog2(COMMIT_WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CW_W-1:0]  ncommit_i,
  input  logic [CW_W-1:0]  nwork_i,
  output logic [CNT_W-1:0] inst_cnt_o,
  output logic [CNT_W-1:0] fullbw_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inst_cnt_o   <= '0;
      fullbw_cnt_o <= '0;
    end else if (en_i) begin
      inst_cnt_o <= inst_cnt_o + CNT_W'(nwork_i);
      if (ncommit_i == CW_W'(COMMIT_WIDTH)) fullbw_cnt_o <= fullbw_cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/retire_trap_ctrl.sv
module retire_trap_ctrl
  import retire_pkg::*;
#(
  parameter int HEAD_DEPTH   = 6,
  parameter int COMMIT_WIDTH = 4,
  parameter int SEQ_W        = 16,
  parameter int TRAP_LATENCY = 5,
  parameter int CNT_W        = 16,
  localparam int CW_W        = $clog2(COMMIT_WIDTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [HEAD_DEPTH-1:0]       head_vld_i,
  input  logic [HEAD_DEPTH-1:0]       head_rdy_i,
  input  logic [HEAD_DEPTH-1:0]       head_sq_i,
  input  logic [HEAD_DEPTH-1:0]       head_exec_i,
  input  logic [HEAD_DEPTH-1:0]       head_nonspec_i,
  input  logic [HEAD_DEPTH-1:0]       head_load_i,
  input  logic [HEAD_DEPTH-1:0]       head_fault_i,
  input  logic [HEAD_DEPTH-1:0]       head_nop_i,
  input  logic [HEAD_DEPTH*SEQ_W-1:0] head_seq_i,
  input  logic                        stores_pend_i,
  input  logic                        drain_req_i,
  input  logic                        rob_empty_i,
  output logic [HEAD_DEPTH-1:0]       pop_o,
  output logic [CW_W-1:0]             commit_cnt_o,
  output logic                        release_vld_o,
  output logic [SEQ_W-1:0]            release_seq_o,
  output logic                        release_uncached_o,
  output logic                        trap_pending_o,
  output logic                        trap_squash_o,
  output logic [CNT_W-1:0]            inst_cnt_o,
  output logic [CNT_W-1:0]            fullbw_cnt_o,
  output logic                        drained_o
);
  head_flags_t [HEAD_DEPTH-1:0] flags;
  logic [HEAD_DEPTH-1:0] pop_d;
  logic [CW_W-1:0] ncommit_d, nwork_d;
  logic rel_vld_d, rel_unc_d, trap_fire_d, scan_en;
  logic [SEQ_W-1:0] rel_seq_d;

  for (genvar g = 0; g < HEAD_DEPTH; g++) begin : g_pack
    assign flags[g] = '{vld: head_vld_i[g], rdy: head_rdy_i[g], sq: head_sq_i[g],
                        exec: head_exec_i[g], nonspec: head_nonspec_i[g],
                        load: head_load_i[g], fault: head_fault_i[g], nop: head_nop_i[g]};
  end

  // walk is frozen while a trap counts down
  assign scan_en = tick_i && !trap_pending_o;

  retire_scan #(
    .HEAD_DEPTH(HEAD_DEPTH), .COMMIT_WIDTH(COMMIT_WIDTH), .SEQ_W(SEQ_W)
  ) scan_i (
    .en_i(scan_en), .flags_i(flags), .seq_i(head_seq_i), .stores_pend_i(stores_pend_i),
    .pop_o(pop_d), .ncommit_o(ncommit_d), .nwork_o(nwork_d),
    .rel_vld_o(rel_vld_d), .rel_unc_o(rel_unc_d), .rel_seq_o(rel_seq_d),
    .trap_fire_o(trap_fire_d)
  );

  trap_timer #(.TRAP_LATENCY(TRAP_LATENCY)) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(trap_fire_d),
    .pending_o(trap_pending_o), .squash_o(trap_squash_o)
  );

  retire_counters #(.COMMIT_WIDTH(COMMIT_WIDTH), .CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(scan_en),
    .ncommit_i(ncommit_d), .nwork_i(nwork_d),
    .inst_cnt_o(inst_cnt_o), .fullbw_cnt_o(fullbw_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_o              <= '0;
      commit_cnt_o       <= '0;
      release_vld_o      <= 1'b0;
      release_seq_o      <= '0;
      release_uncached_o <= 1'b0;
      drained_o          <= 1'b0;
    end else begin
      pop_o              <= pop_d;
      commit_cnt_o       <= ncommit_d;
      release_vld_o      <= rel_vld_d;
      release_uncached_o <= rel_unc_d;
      if (rel_vld_d) release_seq_o <= rel_seq_d;
      drained_o          <= drain_req_i && rob_empty_i && !stores_pend_i;
    end
  end
endmodule

// File: rtl/retire_trap_ctrl_chk.sv
module retire_trap_ctrl_chk #(
  parameter int HEAD_DEPTH   = 6,
  parameter int COMMIT_WIDTH = 4,
  parameter int SEQ_W        = 16,
  parameter int CNT_W        = 16,
  localparam int CW_W        = $clog2(COMMIT_WIDTH + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  stores_pend_i,
  input logic                  drain_req_i,
  input logic                  rob_empty_i,
  input logic [HEAD_DEPTH-1:0] pop_o,
  input logic [CW_W-1:0]       commit_cnt_o,
  input logic                  release_vld_o,
  input logic                  release_uncached_o,
  input logic                  trap_pending_o,
  input logic                  trap_squash_o,
  input logic [CNT_W-1:0]      inst_cnt_o,
  input logic [CNT_W-1:0]      fullbw_cnt_o,
  input logic                  drained_o
);
  AST_POP_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pop_o + HEAD_DEPTH'(1)) & pop_o) == '0); // R1
  AST_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_cnt_o <= CW_W'(COMMIT_WIDTH)); // R1
  AST_COMMIT_POPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pop_o) >= int'(commit_cnt_o)); // R2
  AST_UNC_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_uncached_o |-> release_vld_o); // R4
  AST_TRAP_NO_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_pending_o) |-> !release_vld_o); // R5
  AST_SQUASH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_squash_o |=> !trap_squash_o); // R6
  AST_SQUASH_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_squash_o |-> (!trap_pending_o && $past(trap_pending_o))); // R6
  AST_NO_POP_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trap_pending_o) |-> (pop_o == '0)); // R7
  AST_FULLBW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fullbw_cnt_o != $past(fullbw_cnt_o)) |-> (commit_cnt_o == CW_W'(COMMIT_WIDTH))); // R8
  AST_WORK_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_cnt_o - $past(inst_cnt_o)) <= CNT_W'(commit_cnt_o)); // R9
  AST_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> $past(drain_req_i && rob_empty_i && !stores_pend_i)); // R10
endmodule

bind retire_trap_ctrl retire_trap_ctrl_chk #(
  .HEAD_DEPTH(HEAD_DEPTH), .COMMIT_WIDTH(COMMIT_WIDTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .stores_pend_i(stores_pend_i),
  .drain_req_i(drain_req_i), .rob_empty_i(rob_empty_i), .pop_o(pop_o),
  .commit_cnt_o(commit_cnt_o), .release_vld_o(release_vld_o),
  .release_uncached_o(release_uncached_o), .trap_pending_o(trap_pending_o),
  .trap_squash_o(trap_squash_o), .inst_cnt_o(inst_cnt_o),
  .fullbw_cnt_o(fullbw_cnt_o), .drained_o(drained_o)
);

// File: tb/retire_trap_ctrl_tb_top.sv
module retire_trap_ctrl_tb_top;
  localparam int D  = 6;
  localparam int W  = 4;
  localparam int SW = 16;
  localparam int L  = 5;
  localparam int CN = 16;
  localparam int CWW = $clog2(W + 1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [D-1:0] vld, rdy, sq, ex, ns, ld, ft, nop;
  logic [D*SW-1:0] seq;
  logic stp = 1'b0, drq = 1'b0, remp = 1'b0;
  logic [D-1:0] pop;
  logic [CWW-1:0] ccnt;
  logic rvld, runc, tpend, tsq, drained;
  logic [SW-1:0] rseq;
  logic [CN-1:0] icnt, fcnt;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  retire_trap_ctrl #(.HEAD_DEPTH(D), .COMMIT_WIDTH(W), .SEQ_W(SW), .TRAP_LATENCY(L), .CNT_W(CN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .head_vld_i(vld), .head_rdy_i(rdy), .head_sq_i(sq), .head_exec_i(ex),
    .head_nonspec_i(ns), .head_load_i(ld), .head_fault_i(ft), .head_nop_i(nop),
    .head_seq_i(seq), .stores_pend_i(stp), .drain_req_i(drq), .rob_empty_i(remp),
    .pop_o(pop), .commit_cnt_o(ccnt), .release_vld_o(rvld), .release_seq_o(rseq),
    .release_uncached_o(runc), .trap_pending_o(tpend), .trap_squash_o(tsq),
    .inst_cnt_o(icnt), .fullbw_cnt_o(fcnt), .drained_o(drained)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_win();
    vld = '0; rdy = '0; sq = '0; ex = '0; ns = '0; ld = '0; ft = '0; nop = '0;
    for (int i = 0; i < D; i++) seq[i*SW +: SW] = SW'(100 + i);
  endtask

  task automatic norm(input int i);
    vld[i] = 1'b1; rdy[i] = 1'b1; ex[i] = 1'b1;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 pop", pop, 0);
    chk("R11 release", rvld, 0);
    chk("R11 trap", {tpend, tsq}, 0);
    chk("R11 counters", {icnt, fcnt}, 0);
    chk("R11 drained", drained, 0);
  endtask

  task automatic t_basic();
    logic [CN-1:0] i0;
    i0 = icnt;
    clear_win(); norm(0); norm(1); norm(2); vld[3] = 1'b1; ex[3] = 1'b1;
    do_tick();
    chk("R1 stop at not ready pop", pop, 6'b000111);
    chk("R1 commit cnt", ccnt, 3);
    chk("R9 work cnt", icnt - i0, 3);
    @(posedge clk); #1;
    chk("R1 no tick no pop", pop, 0);
  endtask

  task automatic t_width();
    logic [CN-1:0] f0;
    f0 = fcnt;
    clear_win(); for (int i = 0; i < D; i++) norm(i);
    do_tick();
    chk("R1 budget pop", pop, 6'b001111);
    chk("R1 budget cnt", ccnt, W);
    chk("R8 fullbw inc", fcnt - f0, 1);
  endtask

  task automatic t_squash();
    logic [CN-1:0] i0, f0;
    i0 = icnt; f0 = fcnt;
    clear_win(); for (int i = 0; i < D; i++) norm(i);
    sq[0] = 1'b1; sq[1] = 1'b1;
    do_tick();
    chk("R2 squashed free pop", pop, 6'b111111);
    chk("R2 commit cnt", ccnt, W);
    chk("R9 work cnt squash", icnt - i0, 4);
    chk("R8 fullbw squash", fcnt - f0, 1);
    clear_win(); norm(0); norm(1);
    do_tick();
    chk("R8 no fullbw partial", fcnt - f0, 1);
  endtask

  task automatic t_nop();
    logic [CN-1:0] i0;
    i0 = icnt;
    clear_win(); norm(0); nop[0] = 1'b1; norm(1);
    do_tick();
    chk("R9 nop pops", pop, 6'b000011);
    chk("R9 nop commit cnt", ccnt, 2);
    chk("R9 nop not counted", icnt - i0, 1);
  endtask

  task automatic t_nonspec();
    clear_win(); norm(0); vld[1] = 1'b1; rdy[1] = 1'b1; ns[1] = 1'b1;
    do_tick();
    chk("R3 not first pop", pop, 6'b000001);
    chk("R3 not first no release", rvld, 0);
    clear_win(); vld[0] = 1'b1; rdy[0] = 1'b1; ns[0] = 1'b1; stp = 1'b1;
    do_tick();
    chk("R3 stores pending no release", {rvld, pop}, 0);
    stp = 1'b0; seq[0 +: SW] = 16'h3a5c;
    do_tick();
    chk("R3 release", rvld, 1);
    chk("R3 release seq", rseq, 16'h3a5c);
    chk("R3 not uncached", runc, 0);
    chk("R3 no pop", pop, 0);
  endtask

  task automatic t_load();
    clear_win(); sq[0] = 1'b1; norm(0); vld[1] = 1'b1; rdy[1] = 1'b1; ld[1] = 1'b1;
    seq[SW +: SW] = 16'h0777; stp = 1'b1;
    do_tick();
    stp = 1'b0;
    chk("R4 uncached release", {rvld, runc}, 2'b11);
    chk("R4 load seq", rseq, 16'h0777);
    chk("R4 load pop", pop, 6'b000001);
  endtask

  task automatic t_fault();
    clear_win(); norm(0); norm(1); ft[1] = 1'b1;
    do_tick();
    chk("R5 not first waits", {tpend, pop}, 7'b0000001);
    clear_win(); norm(0); ft[0] = 1'b1; stp = 1'b1;
    do_tick();
    chk("R5 stores waits", tpend, 0);
    stp = 1'b0;
    do_tick();
    chk("R5 trap armed", tpend, 1);
    chk("R5 fault no pop", pop, 0);
    clear_win(); for (int i = 0; i < D; i++) norm(i);
    tick = 1'b1;
    for (int k = 1; k <= L; k++) begin
      @(posedge clk); #1;
      chk("R7 no pop during trap", pop, 0);
      if (k < L) chk("R6 still pending", {tpend, tsq}, 2'b10);
      else       chk("R6 squash at latency", {tpend, tsq}, 2'b01);
    end
    @(posedge clk); #1;
    tick = 1'b0;
    chk("R6 squash one cycle", tsq, 0);
    chk("R7 resume after trap", pop, 6'b001111);
  endtask

  task automatic t_drain();
    drq = 1'b1; remp = 1'b0;
    @(posedge clk); #1;
    chk("R10 rob busy", drained, 0);
    remp = 1'b1; stp = 1'b1;
    @(posedge clk); #1;
    chk("R10 stores pending", drained, 0);
    stp = 1'b0;
    @(posedge clk); #1;
    chk("R10 drained", drained, 1);
    drq = 1'b0;
    @(posedge clk); #1;
    chk("R10 drop", drained, 0);
  endtask

  initial begin
    clear_win();
    #20 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_width();
    t_squash();
    t_nop();
    t_nonspec();
    t_load();
    t_fault();
    t_drain();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule